// File: doc/BRIEF.md
# LCD Pixel Output Packer

This block sits between the pixel colour path and the pins of an LCD panel. It takes one pixel per handshake, as three colour channels, and keeps only the most significant bits of each channel. It arranges those bits on an 18-bit pixel bus in one of four layouts, which gives the panel one, four or two-and-two-thirds pixels per shift clock. A new bus word is produced on each cycle in which the shift-clock enable is high. Between enables the bus holds its last word.

Pixel input uses a valid/ready stream. A pixel transfers on a rising clock edge when `pix_valid` and `pix_ready` are both high. The source must hold the pixel and `pix_valid` until that edge. The block drops `pix_ready` when its 24-bit holding buffer has no room for another pixel after the word taken in the current cycle. This applies back-pressure, so the source waits rather than loses data.

Inside, the block works on a single bit stream. Each pixel adds its field to the top of the stream. Each shift-clock enable takes one word off the bottom of the stream. In the fractional mode, this makes pixels straddle word boundaries in a cycle of eight pixels over three words. The output enable clears the stream, so packing restarts at the first word of that cycle. If a shift-clock enable arrives when the stream holds less than one word, that word is emitted as zeros and an underrun flag is raised.

Top module: `lcdpk_top`

## Requirements
- R1: With `mode` = 00 (565), each word carries one pixel. Red bits [7:3] are on P[17:13], green bits [7:2] are on P[11:6] and blue bits [7:3] are on P[5:1].
- R2: With `mode` = 01 (555), each word carries one pixel. Red bits [7:3] are on P[17:13], green bits [7:3] are on P[11:7] and blue bits [7:3] are on P[5:1].
- R3: With `mode` = 10 (3 bits per pixel), each pixel contributes a triple: blue MSB in its lowest bit, green MSB in the middle bit and red MSB in its highest bit. The triples of pixels 0..7 fill P[7:0] over three words: word 0 = {p2[1:0], p1, p0}, word 1 = {p5[0], p4, p3, p2[2]} and word 2 = {p7, p6, p5[2:1]}. The cycle then repeats.
- R4: With `mode` = 11 (4 pixels per word), pixel n of the word occupies P[4n+3:4n], as the nibble {red bit 6, red bit 7, green bit 7, blue bit 7}, with blue on the lowest bit.
- R5: Bus bits that the selected layout does not use are 0: P[12] and P[0] in 565; P[12], P[6] and P[0] in 555; P[17:8] in the 3-bit mode; P[17:16] in the 4-pixel mode.
- R6: While `pix_out_en` is low, the following hold:
  - `pdata` and `underrun` go to 0 at the next edge.
  - `pix_ready` is low.
  - Pending pixel bits are discarded, so the first word after re-enabling starts with the first pixel accepted after re-enabling.
- R7: If `shift_en` is high while fewer bits are pending than one word needs, the word is emitted as all zeros with `underrun` high. The pending bits are kept for the next word. A pixel accepted in that same cycle does not fill the word.
- R8: With `pix_out_en` high and `shift_en` low, `pdata` and `underrun` keep their values.
- R9: A pixel is consumed only on an edge where `pix_valid` and `pix_ready` are both high. A pixel accepted in the cycle of a shift-clock enable appears in a later word. `pix_ready` is high whenever `pix_out_en` is high and no bits are pending.
- R10: After reset, `pdata` is 0, `underrun` is 0 and no bits are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Layout select: 00 565, 01 555, 10 3-bit, 11 four per word; change only while `pix_out_en` is low |
| pix_out_en | input | 1 | Pixel output enable; low clears the bus and the packing state |
| shift_en | input | 1 | One-cycle strobe per shift clock; emits one bus word |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_red | input | 8 | Red channel of the offered pixel |
| pix_grn | input | 8 | Green channel of the offered pixel |
| pix_blu | input | 8 | Blue channel of the offered pixel |
| pdata | output | 18 | Pixel data bus |
| underrun | output | 1 | High for a word emitted without enough pending data |

## Verification
Word extraction and pixel intake can fall on the same clock edge. A word is taken from the bottom of the stream while a new pixel is appended above what remains. The bench provokes this by driving `shift_en` and `pix_valid` together, both in random runs and in a directed case where the buffer is empty. In that directed case the word must come out as an underrun and the new pixel must land in the following word. The bench also reads `pix_ready` after each cycle's inputs settle, and checks that a pixel can enter in the same cycle that a full buffer releases a word.

// File: rtl/lcdpk_pkg.sv
`timescale 1ns/1ps
package lcdpk_pkg;

  localparam int BUS_W = 18;

  typedef enum logic [1:0] {
    PK_565  = 2'b00,
    PK_555  = 2'b01,
    PK_TRI  = 2'b10,
    PK_QUAD = 2'b11
  } pk_mode_e;

  // Bits removed from the stream per shift-clock word.
  function automatic int word_bits(pk_mode_e m);
    case (m)
      PK_TRI:  return 8;
      PK_QUAD: return 16;
      default: return BUS_W;
    endcase
  endfunction

  // Bits added to the stream per accepted pixel.
  function automatic int pix_bits(pk_mode_e m);
    case (m)
      PK_TRI:  return 3;
      PK_QUAD: return 4;
      default: return BUS_W;
    endcase
  endfunction

endpackage

// File: rtl/lcdpk_fmt.sv
`timescale 1ns/1ps
module lcdpk_fmt
  import lcdpk_pkg::*;
#(
  parameter int COLOR_W = 8
) (
  input  pk_mode_e             mode,
  input  logic [COLOR_W-1:0]   red,
  input  logic [COLOR_W-1:0]   grn,
  input  logic [COLOR_W-1:0]   blu,
  output logic [BUS_W-1:0]     field
);

  localparam int MSB = COLOR_W - 1;

  // Right-aligned field that one pixel adds to the stream.
  always_comb begin
    field = '0;
    case (mode)
      PK_565: begin
        field[17:13] = red[MSB -: 5];
        field[11:6]  = grn[MSB -: 6];
        field[5:1]   = blu[MSB -: 5];
      end
      PK_555: begin
        field[17:13] = red[MSB -: 5];
        field[11:7]  = grn[MSB -: 5];
        field[5:1]   = blu[MSB -: 5];
      end
      PK_TRI:  field[2:0] = {red[MSB], grn[MSB], blu[MSB]};
      default: field[3:0] = {red[MSB-1], red[MSB], grn[MSB], blu[MSB]};
    endcase
  end

endmodule

// File: rtl/lcdpk_acc.sv
`timescale 1ns/1ps
module lcdpk_acc
  import lcdpk_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic               push,
  input  pk_mode_e           mode,
  input  logic [BUS_W-1:0]   field,
  output logic [BUS_W-1:0]   word,
  output logic               word_ok,
  output logic               space
);

  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_kept, acc_d, low_mask;
  logic [CNT_W-1:0] cnt_q, cnt_kept, cnt_d, wb, pb;

  // Extraction side: word at the bottom, what stays after this cycle's take.
  always_comb begin
    wb       = CNT_W'(word_bits(mode));
    pb       = CNT_W'(pix_bits(mode));
    word_ok  = (cnt_q >= wb);
    low_mask = ~({ACC_W{1'b1}} << wb);
    word     = BUS_W'(acc_q & low_mask);
    if (take && word_ok) begin
      acc_kept = acc_q >> wb;
      cnt_kept = cnt_q - wb;
    end else begin
      acc_kept = acc_q;
      cnt_kept = cnt_q;
    end
    space = ({1'b0, cnt_kept} + {1'b0, pb}) <= (CNT_W + 1)'(ACC_W);
  end

  // Intake side: new field lands just above the bits that remain.
  always_comb begin
    acc_d = acc_kept;
    cnt_d = cnt_kept;
    if (push) begin
      acc_d = acc_kept | (ACC_W'(field) << cnt_kept);
      cnt_d = cnt_kept + pb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lcdpk_top.sv
`timescale 1ns/1ps
module lcdpk_top
  import lcdpk_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int ACC_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                pix_out_en,
  input  logic                shift_en,
  input  logic                pix_valid,
  output logic                pix_ready,
  input  logic [COLOR_W-1:0]  pix_red,
  input  logic [COLOR_W-1:0]  pix_grn,
  input  logic [COLOR_W-1:0]  pix_blu,
  output logic [BUS_W-1:0]    pdata,
  output logic                underrun
);

  pk_mode_e          mode_e;
  logic [BUS_W-1:0]  field, word;
  logic              word_ok, space, take, push;

  assign mode_e    = pk_mode_e'(mode);
  assign take      = pix_out_en && shift_en;
  assign pix_ready = pix_out_en && space;
  assign push      = pix_valid && pix_ready;

  lcdpk_fmt #(.COLOR_W(COLOR_W)) u_fmt (
    .mode  (mode_e),
    .red   (pix_red),
    .grn   (pix_grn),
    .blu   (pix_blu),
    .field (field)
  );

  lcdpk_acc #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!pix_out_en),
    .take    (take),
    .push    (push),
    .mode    (mode_e),
    .field   (field),
    .word    (word),
    .word_ok (word_ok),
    .space   (space)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !pix_out_en) begin
      pdata    <= '0;
      underrun <= 1'b0;
    end else if (shift_en) begin
      pdata    <= word_ok ? word : '0;
      underrun <= !word_ok;
    end
  end

endmodule

// File: rtl/lcdpk_chk.sv
`timescale 1ns/1ps
module lcdpk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        pix_out_en,
  input logic        shift_en,
  input logic        pix_ready,
  input logic [17:0] pdata,
  input logic        underrun
);

  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_out_en |=> (pdata == 18'd0 && !underrun));

  a_r6_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_out_en |-> !pix_ready);

  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_en && !shift_en) |=> ($stable(pdata) && $stable(underrun)));

  a_r7_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (pdata == 18'd0));

  a_r5_unused_565: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_en && mode == 2'b00) |=> (pdata[12] == 1'b0 && pdata[0] == 1'b0));

  a_r5_unused_555: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_en && mode == 2'b01) |=>
      (pdata[12] == 1'b0 && pdata[6] == 1'b0 && pdata[0] == 1'b0));

  a_r5_unused_tri: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_en && mode == 2'b10) |=> (pdata[17:8] == 10'd0));

  a_r5_unused_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_en && mode == 2'b11) |=> (pdata[17:16] == 2'd0));

endmodule

bind lcdpk_top lcdpk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .pix_out_en (pix_out_en),
  .shift_en   (shift_en),
  .pix_ready  (pix_ready),
  .pdata      (pdata),
  .underrun   (underrun)
);

// File: tb/lcdpk_top_test.sv
`timescale 1ns/1ps
module lcdpk_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        pix_out_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_red = '0, pix_grn = '0, pix_blu = '0;
  logic [17:0] pdata;
  logic        underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        en_v = 1'b0;
  logic [1:0]  mode_v = 2'b00;
  logic [63:0] ms = '0;
  int          mc = 0;
  logic [17:0] eb = '0;
  logic        eu = 1'b0;

  always #2.5 clk = ~clk;

  lcdpk_top uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pix_out_en(pix_out_en),
    .shift_en(shift_en), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
    .pdata(pdata), .underrun(underrun)
  );

  function automatic int wbits(logic [1:0] m);
    return (m == 2'b10) ? 8 : (m == 2'b11) ? 16 : 18;
  endfunction

  function automatic int pbits(logic [1:0] m);
    return (m == 2'b10) ? 3 : (m == 2'b11) ? 4 : 18;
  endfunction

  function automatic logic [17:0] exp_bits(logic [1:0] m, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    case (m)
      2'b00:   return {r[7:3], 1'b0, g[7:2], b[7:3], 1'b0};
      2'b01:   return {r[7:3], 1'b0, g[7:3], 1'b0, b[7:3], 1'b0};
      2'b10:   return {15'd0, r[7], g[7], b[7]};
      default: return {14'd0, r[6], r[7], g[7], b[7]};
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive, model the edge, compare after it.
  task automatic cyc(logic s, logic v, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    logic rdy;
    int   wb;
    string tag;
    @(negedge clk);
    pix_out_en = en_v; mode = mode_v; shift_en = s;
    pix_valid = v; pix_red = r; pix_grn = g; pix_blu = b;
    #1;
    rdy = pix_ready;
    if (!en_v) chk("R6 ready while disabled", 32'(rdy), 0);
    else if (mc == 0) chk("R9 ready when empty", 32'(rdy), 1);
    wb = wbits(mode_v);
    if (!en_v || !rst_n) begin
      ms = '0; mc = 0; eb = '0; eu = 1'b0;
    end else begin
      if (s) begin
        if (mc >= wb) begin
          eb = 18'(ms & ((64'd1 << wb) - 64'd1));
          ms = ms >> wb; mc -= wb; eu = 1'b0;
        end else begin
          eb = '0; eu = 1'b1;
        end
      end
      if (v && rdy) begin
        ms = ms | (64'(exp_bits(mode_v, r, g, b)) << mc);
        mc += pbits(mode_v);
      end
    end
    @(posedge clk);
    #1;
    if (!en_v) tag = "R6";
    else if (!s) tag = "R8";
    else if (eu) tag = "R7";
    else tag = mode_tag(mode_v);
    chk(tag, 32'(pdata), 32'(eb));
    chk(eu ? "R7 flag" : "R7 flag clear", 32'(underrun), 32'(eu));
  endtask

  task automatic restart(logic [1:0] m);
    en_v = 1'b0;
    cyc(0, 0, 0, 0, 0);
    mode_v = m; en_v = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] t [8];
    logic [7:0] rr [8], gg [8], bb [8];
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R10 bus after reset", 32'(pdata), 0);
    chk("R10 flag after reset", 32'(underrun), 0);

    // R1 565 single pixel
    restart(2'b00);
    cyc(0, 1, 8'hA5, 8'h3C, 8'hC3);
    cyc(1, 0, 0, 0, 0);
    chk("R1 direct", 32'(pdata), 32'({5'h14, 1'b0, 6'h0F, 5'h18, 1'b0}));
    // R8 hold over idle cycles
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // full buffer releases a word and accepts a pixel in one cycle (R9)
    cyc(0, 1, 8'hFF, 8'hFF, 8'hFF);
    cyc(1, 1, 8'h11, 8'h22, 8'h33);
    cyc(1, 0, 0, 0, 0);
    chk("R9 same-cycle intake", 32'(pdata), 32'(exp_bits(2'b00, 8'h11, 8'h22, 8'h33)));

    // R2 555
    restart(2'b01);
    cyc(0, 1, 8'hFF, 8'hFF, 8'hFF);
    cyc(1, 0, 0, 0, 0);
    chk("R2 direct", 32'(pdata), 32'h3EFBE);

    // R3 eight pixels over three words
    restart(2'b10);
    for (int i = 0; i < 8; i++) begin
      rr[i] = 8'($urandom); gg[i] = 8'($urandom); bb[i] = 8'($urandom);
      t[i] = {rr[i][7], gg[i][7], bb[i][7]};
      cyc(0, 1, rr[i], gg[i], bb[i]);
    end
    cyc(1, 0, 0, 0, 0);
    chk("R3 word0", 32'(pdata), 32'({t[2][1:0], t[1], t[0]}));
    cyc(1, 0, 0, 0, 0);
    chk("R3 word1", 32'(pdata), 32'({t[5][0], t[4], t[3], t[2][2]}));
    cyc(1, 0, 0, 0, 0);
    chk("R3 word2", 32'(pdata), 32'({t[7], t[6], t[5][2:1]}));

    // R7 underrun, including a pixel arriving in the same cycle
    cyc(1, 1, 8'h80, 8'h80, 8'h80);
    chk("R7 coincident underrun", 32'(underrun), 1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 8'h80, 8'h00);
    cyc(1, 0, 0, 0, 0);
    chk("R7 pending kept", 32'(pdata), 32'({2'b10, 3'b010, 3'b111}));

    // R6 disable discards pending bits
    cyc(0, 1, 8'h80, 8'h80, 8'h80);
    cyc(0, 1, 8'h80, 8'h80, 8'h80);
    restart(2'b10);
    for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 8'h00, 8'h80);
    cyc(1, 0, 0, 0, 0);
    chk("R6 restart at word0", 32'(pdata), 32'({2'b01, 3'b001, 3'b001}));

    // R4 quad
    restart(2'b11);
    cyc(0, 1, 8'h40, 8'h00, 8'h00);
    cyc(0, 1, 8'h80, 8'h00, 8'h00);
    cyc(0, 1, 8'h00, 8'h80, 8'h00);
    cyc(0, 1, 8'h00, 8'h00, 8'h80);
    cyc(1, 0, 0, 0, 0);
    chk("R4 direct", 32'(pdata), 32'h1248);

    // random segments
    for (int seg = 0; seg < 16; seg++) begin
      restart(2'(seg % 4));
      for (int k = 0; k < 200; k++) begin
        cyc(($urandom % 100) < 40, ($urandom % 100) < 70,
            8'($urandom), 8'($urandom), 8'($urandom));
      end
    end

    en_v = 1'b0;
    cyc(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule